// File: doc/BRIEF.md
# Two-Wire Slave Bus Front End for a Quad Potentiometer Controller

This block is the slave side of a two-wire serial bus that fronts a four-channel digital potentiometer controller. It samples the SCL and SDA pad inputs with the system clock and passes them through two-flop synchronizers. It finds start and stop conditions on the synchronized samples and acknowledges a slave address made of a fixed 4-bit type code and four strap pins. SDA is driven only as an open-drain pull-down enable.

The address byte carries no direction bit. Direction and length come from the opcode in the upper nibble of the instruction byte that follows. Accepted instructions go to a command executor as a one-cycle strobe with the byte. A trailing write byte is handed over the same way. For a read, one byte from the executor is shifted out MSB first. For the step instruction, each completed SCL pulse is reported as one up or down step. While the executor reports a nonvolatile store in progress, the block refuses its own address, so a master can poll for completion by sending start and address until the address is acknowledged.

Top module: `pot_bus_slave`

## Requirements
- R1: A falling SDA while SCL is high (both synchronized) is a start: from any state, including the middle of a byte, it restarts address reception at bit 0. A rising SDA while SCL is high is a stop: it releases SDA and returns the block to idle.
- R2: The first byte after a start arrives MSB first. The block acknowledges it by setting `sda_oe` to 1 (SDA pulled low) for the ninth SCL clock only when bits 7:4 equal 4'b0101 and bits 3:0 equal `dev_strap`. On a mismatch it does not acknowledge and answers nothing until the next start.
- R3: If `store_busy` is 1 when the address byte completes, the address is not acknowledged. Once `store_busy` is 0, the same address is acknowledged again.
- R4: The upper nibble of the instruction byte is the opcode. Opcodes 0001, 0010, 1000, 1001, 1010, 1011, 1100, 1101 and 1110 are acknowledged, and `cmd_valid` pulses once with `cmd_byte` holding the whole byte. Any other opcode is not acknowledged, gives no pulse and returns the block to idle.
- R5: After opcode 1010 or 1100, the next byte is acknowledged, and `wr_valid` pulses once with `wr_byte` holding it.
- R6: After opcode 1001 or 1011, `rd_data` is captured at the end of the instruction acknowledge clock. It is sent MSB first, one bit per SCL clock, with `sda_oe` equal to the inverse of the bit. SDA is released for the master's acknowledge clock that follows.
- R7: After opcode 0010, every SCL pulse that completes (rises and then falls) gives one `step_pulse`, with `step_up` equal to the SDA level at its rising edge (1 = up, 0 = down). The SCL high phase cut short by a stop gives no step.
- R8: `cmd_close` pulses on a stop only when the transaction reached the end of its sequence: a two-byte command after its instruction acknowledge, a write after its data acknowledge, a read after the master acknowledge clock, or any step session. An address-only poll, a refused address or a refused opcode gives no pulse.
- R9: Out of reset, `sda_oe` and all strobes are 0. `sda_oe` changes only while the synchronized SCL is low.
- R10: Once a two-byte command, write data or read data is finished, any further bytes before the stop are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL pad input |
| sda_in | input | 1 | Raw SDA pad input (wired bus level) |
| sda_oe | output | 1 | 1 pulls SDA low; the block never drives SDA high |
| dev_strap | input | 4 | Strap pins giving the low four address bits |
| store_busy | input | 1 | 1 while the executor runs a nonvolatile store |
| rd_data | input | 8 | Byte to return for a read instruction |
| cmd_valid | output | 1 | One-cycle strobe for an accepted instruction |
| cmd_byte | output | 8 | Last accepted instruction byte |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_byte | output | 8 | Last received write byte |
| step_pulse | output | 1 | One-cycle strobe for one wiper step |
| step_up | output | 1 | Direction of the last step, 1 = up |
| cmd_close | output | 1 | One-cycle strobe when a stop closes a completed command |

## Verification
Random transactions mix matching addresses with single-bit strap errors, wrong type codes and busy windows. This separates a type check from a strap check and shows that the busy refusal does not depend on the address pattern. Opcodes are drawn from both the legal set and arbitrary bytes, so each instruction class (two-byte, write, read, step) is followed through its own length and close rule, and illegal nibbles are refused. Read values and random up/down step strings check bit order and step direction, and every step session ends with the stop-cut pulse that must not count. Directed cases cover a restart after a partial byte, an address-only poll during and after a busy window, and an extra byte after a finished command.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_INSTR,
      ST_IACK,
      ST_WDATA,
      ST_WACK,
      ST_RDATA,
      ST_MACK,
      ST_STEP,
      ST_HOLD
   } pbs_state_e;

   typedef enum logic [2:0] {
      K_BAD,
      K_TWO,
      K_WRITE,
      K_READ,
      K_STEP
   } pbs_kind_e;

   // opcode nibble -> transaction class
   function automatic pbs_kind_e op_kind(input logic [3:0] opc);
      case (opc)
         4'b0001, 4'b1000, 4'b1101, 4'b1110: return K_TWO;
         4'b0010:                            return K_STEP;
         4'b1001, 4'b1011:                   return K_READ;
         4'b1010, 4'b1100:                   return K_WRITE;
         default:                            return K_BAD;
      endcase
   endfunction

endpackage

// File: rtl/pbs_sync.sv
module pbs_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pbs_cond.sv
module pbs_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);

   logic scl_p;
   logic sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_p;
   assign scl_fall  = ~scl_s &  scl_p;
   assign start_evt =  scl_s &  scl_p &  sda_p & ~sda_s;
   assign stop_evt  =  scl_s &  scl_p & ~sda_p &  sda_s;

endmodule

// File: rtl/pbs_engine.sv
module pbs_engine
   import pbs_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int STRAP_W = 4,
   parameter int TYPE_ID = 5,
   localparam int TYPE_W = BYTE_W - STRAP_W,
   localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_evt,
   input  logic               stop_evt,
   input  logic [STRAP_W-1:0] strap,
   input  logic               store_busy,
   input  logic [BYTE_W-1:0]  rd_data,
   output logic               sda_oe,
   output logic               cmd_valid,
   output logic [BYTE_W-1:0]  cmd_byte,
   output logic               wr_valid,
   output logic [BYTE_W-1:0]  wr_byte,
   output logic               step_pulse,
   output logic               step_up,
   output logic               cmd_close,
   output pbs_state_e         state,
   output logic [CNT_W-1:0]   bit_cnt
);

   localparam logic [TYPE_W-1:0] TYPE_V = TYPE_W'(TYPE_ID);
   localparam logic [CNT_W-1:0]  FULL   = CNT_W'(BYTE_W);

   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   pbs_kind_e         kind;
   pbs_kind_e         rx_kind;
   logic              addr_ok;
   logic              step_arm;
   logic              step_dir;

   assign rx_kind = op_kind(rx_sh[BYTE_W-1 -: 4]);
   assign addr_ok = (rx_sh[BYTE_W-1 -: TYPE_W] == TYPE_V)
                 && (rx_sh[STRAP_W-1:0] == strap)
                 && !store_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         rx_sh      <= '0;
         tx_sh      <= '0;
         kind       <= K_BAD;
         sda_oe     <= 1'b0;
         cmd_valid  <= 1'b0;
         cmd_byte   <= '0;
         wr_valid   <= 1'b0;
         wr_byte    <= '0;
         step_pulse <= 1'b0;
         step_up    <= 1'b0;
         step_arm   <= 1'b0;
         step_dir   <= 1'b0;
         cmd_close  <= 1'b0;
      end else begin
         cmd_valid  <= 1'b0;
         wr_valid   <= 1'b0;
         step_pulse <= 1'b0;
         cmd_close  <= 1'b0;
         if (stop_evt) begin
            cmd_close <= (state == ST_HOLD) || (state == ST_STEP);
            state     <= ST_IDLE;
            sda_oe    <= 1'b0;
            step_arm  <= 1'b0;
            bit_cnt   <= '0;
         end else if (start_evt) begin
            state    <= ST_ADDR;
            sda_oe   <= 1'b0;
            step_arm <= 1'b0;
            bit_cnt  <= '0;
         end else begin
            case (state)
               ST_ADDR, ST_INSTR, ST_WDATA: begin
                  if (scl_rise && bit_cnt < FULL) begin
                     rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == FULL) begin
                     if (state == ST_ADDR) begin
                        if (addr_ok) begin
                           sda_oe <= 1'b1;
                           state  <= ST_AACK;
                        end else begin
                           state  <= ST_IDLE;
                        end
                     end else if (state == ST_INSTR) begin
                        if (rx_kind != K_BAD) begin
                           sda_oe    <= 1'b1;
                           state     <= ST_IACK;
                           cmd_valid <= 1'b1;
                           cmd_byte  <= rx_sh;
                           kind      <= rx_kind;
                        end else begin
                           state     <= ST_IDLE;
                        end
                     end else begin
                        sda_oe   <= 1'b1;
                        state    <= ST_WACK;
                        wr_valid <= 1'b1;
                        wr_byte  <= rx_sh;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     state   <= ST_INSTR;
                  end
               end
               ST_IACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     case (kind)
                        K_READ: begin
                           tx_sh  <= rd_data;
                           sda_oe <= ~rd_data[BYTE_W-1];
                           state  <= ST_RDATA;
                        end
                        K_WRITE: begin
                           sda_oe <= 1'b0;
                           state  <= ST_WDATA;
                        end
                        K_STEP: begin
                           sda_oe <= 1'b0;
                           state  <= ST_STEP;
                        end
                        default: begin
                           sda_oe <= 1'b0;
                           state  <= ST_HOLD;
                        end
                     endcase
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_HOLD;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise && bit_cnt < FULL) begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bit_cnt == FULL) begin
                        sda_oe <= 1'b0;
                        state  <= ST_MACK;
                     end else begin
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tx_sh[BYTE_W-2];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_fall) state <= ST_HOLD;
               end
               ST_STEP: begin
                  if (scl_rise) begin
                     step_dir <= sda_s;
                     step_arm <= 1'b1;
                  end else if (scl_fall && step_arm) begin
                     step_pulse <= 1'b1;
                     step_up    <= step_dir;
                     step_arm   <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/pot_bus_slave.sv
module pot_bus_slave
   import pbs_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int STRAP_W     = 4,
   parameter int TYPE_ID     = 5,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(BYTE_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_in,
   input  logic               sda_in,
   output logic               sda_oe,
   input  logic [STRAP_W-1:0] dev_strap,
   input  logic               store_busy,
   input  logic [BYTE_W-1:0]  rd_data,
   output logic               cmd_valid,
   output logic [BYTE_W-1:0]  cmd_byte,
   output logic               wr_valid,
   output logic [BYTE_W-1:0]  wr_byte,
   output logic               step_pulse,
   output logic               step_up,
   output logic               cmd_close
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pot_bus_slave: SYNC_STAGES must be at least 2");
      end
      if (BYTE_W != 8) begin : g_bad_byte
         $error("pot_bus_slave: BYTE_W must be 8, the opcode sits in the top nibble");
      end
      if (STRAP_W < 1 || STRAP_W > BYTE_W - 1) begin : g_bad_strap
         $error("pot_bus_slave: STRAP_W must leave room for a type code");
      end
   endgenerate

   logic [1:0]       pad_s;
   logic             scl_s;
   logic             sda_s;
   logic             scl_rise;
   logic             scl_fall;
   logic             start_evt;
   logic             stop_evt;
   pbs_state_e       eng_state;
   logic [CNT_W-1:0] eng_cnt;

   pbs_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (2),
      .RST_VAL (2'b11)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     (pad_s)
   );

   assign scl_s = pad_s[1];
   assign sda_s = pad_s[0];

   pbs_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   pbs_engine #(
      .BYTE_W  (BYTE_W),
      .STRAP_W (STRAP_W),
      .TYPE_ID (TYPE_ID)
   ) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_s      (sda_s),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_evt  (start_evt),
      .stop_evt   (stop_evt),
      .strap      (dev_strap),
      .store_busy (store_busy),
      .rd_data    (rd_data),
      .sda_oe     (sda_oe),
      .cmd_valid  (cmd_valid),
      .cmd_byte   (cmd_byte),
      .wr_valid   (wr_valid),
      .wr_byte    (wr_byte),
      .step_pulse (step_pulse),
      .step_up    (step_up),
      .cmd_close  (cmd_close),
      .state      (eng_state),
      .bit_cnt    (eng_cnt)
   );

endmodule

// File: rtl/pbs_checker.sv
module pbs_checker
   import pbs_pkg::*;
#(
   parameter int BYTE_W  = 8,
   localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              start_evt,
   input logic              stop_evt,
   input pbs_state_e        state,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic              sda_oe,
   input logic              store_busy,
   input logic              cmd_valid,
   input logic [BYTE_W-1:0] cmd_byte,
   input logic              wr_valid,
   input logic              step_pulse,
   input logic              cmd_close
);

   assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (state == ST_ADDR && bit_cnt == '0));

   assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (!sda_oe && state == ST_IDLE));

   assert_busy_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) && state == ST_AACK) |-> !$past(store_busy));

   assert_cmd_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (sda_oe && op_kind(cmd_byte[BYTE_W-1 -: 4]) != K_BAD));

   assert_wr_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> sda_oe);

   assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_valid, wr_valid, step_pulse, cmd_close}));

   assert_close_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_close |-> $past(stop_evt));

   assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_s);

endmodule

bind pot_bus_slave pbs_checker #(.BYTE_W(BYTE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_s      (scl_s),
   .start_evt  (start_evt),
   .stop_evt   (stop_evt),
   .state      (eng_state),
   .bit_cnt    (eng_cnt),
   .sda_oe     (sda_oe),
   .store_busy (store_busy),
   .cmd_valid  (cmd_valid),
   .cmd_byte   (cmd_byte),
   .wr_valid   (wr_valid),
   .step_pulse (step_pulse),
   .cmd_close  (cmd_close)
);

// File: tb/tb_pot_bus_slave.sv
module tb_pot_bus_slave;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [3:0] strap = 4'h3;
   logic       busy = 1'b0;
   logic [7:0] rdv = 8'h00;

   logic       sda_oe;
   logic       cmd_valid, wr_valid, step_pulse, step_up, cmd_close;
   logic [7:0] cmd_byte, wr_byte;
   wire        line = sda_m & ~sda_oe;

   pot_bus_slave dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_in     (scl_m),
      .sda_in     (line),
      .sda_oe     (sda_oe),
      .dev_strap  (strap),
      .store_busy (busy),
      .rd_data    (rdv),
      .cmd_valid  (cmd_valid),
      .cmd_byte   (cmd_byte),
      .wr_valid   (wr_valid),
      .wr_byte    (wr_byte),
      .step_pulse (step_pulse),
      .step_up    (step_up),
      .cmd_close  (cmd_close)
   );

   always #4 clk = ~clk;

   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;
   int   n_cmd = 0, n_wr = 0, n_up = 0, n_dn = 0, n_close = 0, oe_viol = 0;
   logic [7:0] last_cmd = 8'h00, last_wr = 8'h00;
   logic oe_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_valid)  begin n_cmd++; last_cmd = cmd_byte; end
         if (wr_valid)   begin n_wr++;  last_wr  = wr_byte;  end
         if (step_pulse) begin if (step_up) n_up++; else n_dn++; end
         if (cmd_close)  n_close++;
         if (sda_oe !== oe_prev && scl_m) oe_viol++;
         oe_prev = sda_oe;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic bit f_addr_ack(input logic [7:0] a, input logic [3:0] s, input logic b);
      return (a[7:4] == 4'b0101) && (a[3:0] == s) && !b;
   endfunction

   // 0 refused, 1 two-byte, 2 write, 3 read, 4 step
   function automatic int f_kind(input logic [3:0] op);
      case (op)
         4'h1, 4'h8, 4'hD, 4'hE: return 1;
         4'hA, 4'hC:             return 2;
         4'h9, 4'hB:             return 3;
         4'h2:                   return 4;
         default:                return 0;
      endcase
   endfunction

   function automatic logic [3:0] f_legal(input int idx);
      case (idx)
         0: return 4'h1; 1: return 4'h2; 2: return 4'h8;
         3: return 4'h9; 4: return 4'hA; 5: return 4'hB;
         6: return 4'hC; 7: return 4'hD; default: return 4'hE;
      endcase
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      tick(2); sda_m = 1'b1; tick(8); scl_m = 1'b1; tick(10); sda_m = 1'b0; tick(10); scl_m = 1'b0;
   endtask

   task automatic bus_stop;
      tick(2); sda_m = 1'b0; tick(8); scl_m = 1'b1; tick(10); sda_m = 1'b1; tick(10);
   endtask

   task automatic clk_bit(input logic b);
      tick(2); sda_m = b; tick(8); scl_m = 1'b1; tick(10); scl_m = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) clk_bit(b[i]);
      tick(2); sda_m = 1'b1; tick(8); scl_m = 1'b1; tick(5);
      ack = ~line;
      tick(5); scl_m = 1'b0;
   endtask

   task automatic recv_byte(output logic [7:0] b, input logic mack);
      for (int i = 7; i >= 0; i--) begin
         tick(2); sda_m = 1'b1; tick(8); scl_m = 1'b1; tick(5);
         b[i] = line;
         tick(5); scl_m = 1'b0;
      end
      clk_bit(~mack);
   endtask

   task automatic do_txn(input logic [7:0] a, input logic [7:0] ins, input logic [7:0] d, input int nst);
      logic aa, ia, da;
      logic [7:0] got;
      int c0, w0, u0, d0, k0, kind, ups;
      bit exp_a, fin;
      c0 = n_cmd; w0 = n_wr; u0 = n_up; d0 = n_dn; k0 = n_close;
      exp_a = f_addr_ack(a, strap, busy);
      kind = f_kind(ins[7:4]);
      fin = 1'b0; ups = 0;
      bus_start;
      send_byte(a, aa);
      chk(aa == exp_a, busy ? "R3 busy address refusal" : "R2 address ack", int'(aa), int'(exp_a));
      if (exp_a && aa) begin
         send_byte(ins, ia);
         chk(ia == (kind != 0), "R4 instruction ack", int'(ia), int'(kind != 0));
         chk(n_cmd - c0 == int'(kind != 0), "R4 cmd_valid count", n_cmd - c0, int'(kind != 0));
         if (kind != 0) begin
            chk(last_cmd == ins, "R4 cmd_byte", int'(last_cmd), int'(ins));
            fin = 1'b1;
            case (kind)
               2: begin
                  send_byte(d, da);
                  chk(da == 1'b1, "R5 data ack", int'(da), 1);
                  chk(n_wr - w0 == 1 && last_wr == d, "R5 wr_byte", int'(last_wr), int'(d));
               end
               3: begin
                  recv_byte(got, 1'b1);
                  chk(got == rdv, "R6 read data", int'(got), int'(rdv));
               end
               4: begin
                  for (int k = 0; k < nst; k++) begin
                     logic b;
                     b = 1'($urandom % 2);
                     ups += int'(b);
                     clk_bit(b);
                  end
               end
               default: ;
            endcase
         end
      end
      bus_stop;
      if (kind == 4 && fin) begin
         chk(n_up - u0 == ups, "R7 up steps", n_up - u0, ups);
         chk(n_dn - d0 == nst - ups, "R7 down steps", n_dn - d0, nst - ups);
      end
      chk(n_close - k0 == int'(fin), "R8 cmd_close on stop", n_close - k0, int'(fin));
   endtask

   initial begin
      logic aa, ia, xa;
      int k0;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      chk(sda_oe == 1'b0, "R9 reset sda_oe", int'(sda_oe), 0);
      chk(n_cmd + n_wr + n_up + n_dn + n_close == 0, "R9 reset strobes", n_cmd + n_wr + n_up + n_dn + n_close, 0);
      void'($urandom(32'd7041));

      // directed corner cases
      rdv = 8'hA5; do_txn({4'h5, strap}, 8'h93, 8'h00, 0);
      rdv = 8'h00; do_txn({4'h5, strap}, 8'hB6, 8'h00, 0);
      rdv = 8'hFF; do_txn({4'h5, strap}, 8'h91, 8'h00, 0);
      do_txn({4'h5, strap}, 8'hC7, 8'h3C, 0);
      do_txn({4'h5, strap}, 8'h21, 8'h00, 4);
      do_txn({4'h5, strap}, 8'h30, 8'h00, 0);
      do_txn({4'h6, strap}, 8'h90, 8'h00, 0);

      // R2 mismatch stays silent until the next start
      k0 = n_close;
      bus_start; send_byte({4'h5, strap ^ 4'h1}, aa); send_byte(8'h90, ia); bus_stop;
      chk(aa == 1'b0, "R2 strap mismatch nack", int'(aa), 0);
      chk(ia == 1'b0, "R2 silent after mismatch", int'(ia), 0);
      chk(n_close == k0, "R8 no close after mismatch", n_close - k0, 0);

      // R3 ack polling during and after a store
      busy = 1'b1;
      bus_start; send_byte({4'h5, strap}, aa); bus_stop;
      chk(aa == 1'b0, "R3 poll while busy", int'(aa), 0);
      busy = 1'b0;
      k0 = n_close;
      bus_start; send_byte({4'h5, strap}, aa); bus_stop;
      chk(aa == 1'b1, "R3 poll after store", int'(aa), 1);
      chk(n_close == k0, "R8 no close for address-only poll", n_close - k0, 0);

      // R1 start in mid-byte restarts address reception
      k0 = n_close;
      bus_start; clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
      bus_start; send_byte({4'h5, strap}, aa); send_byte(8'h14, ia); bus_stop;
      chk(aa == 1'b1, "R1 address after restart", int'(aa), 1);
      chk(ia == 1'b1, "R1 instruction after restart", int'(ia), 1);
      chk(n_close - k0 == 1, "R1 close after restart", n_close - k0, 1);

      // R10 extra byte after a two-byte command
      k0 = n_close;
      bus_start; send_byte({4'h5, strap}, aa); send_byte(8'hE6, ia); send_byte(8'h5A, xa); bus_stop;
      chk(xa == 1'b0, "R10 extra byte refused", int'(xa), 0);
      chk(n_close - k0 == 1, "R8 close after two-byte command", n_close - k0, 1);

      // constrained random traffic
      for (int t = 0; t < 60; t++) begin
         logic [7:0] a, ins, d;
         strap = 4'($urandom);
         busy  = ($urandom % 8) == 0;
         rdv   = 8'($urandom);
         d     = 8'($urandom);
         case ($urandom % 8)
            0:       a = 8'($urandom);
            1:       a = {4'h5, strap ^ (4'h1 << ($urandom % 4))};
            default: a = {4'h5, strap};
         endcase
         if (($urandom % 6) == 0) ins = 8'($urandom);
         else                     ins = {f_legal($urandom % 9), 4'($urandom)};
         do_txn(a, ins, d, 1 + ($urandom % 6));
      end
      busy = 1'b0;

      chk(oe_viol == 0, "R9 sda_oe moved while SCL high", oe_viol, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule